// File: doc/BRIEF.md
# Sixteen-bit ALU with single-bit manipulation

This is a purely combinational arithmetic and logic unit for a small single-cycle RISC core. Each cycle the core gives it two 16-bit operands, a 5-bit operation code, a 4-bit bit index and the flags saved from the previous instruction. In the same cycle the unit returns a 16-bit result and the next values of the carry flag and the zero flag. The core keeps the flags in its own registers and writes the result back itself.

The unit covers four kinds of operation. The arithmetic group is add and subtract, each with and without the saved carry. The shift group moves the first operand one place in either direction, as a shift or as a rotate. The logic group is NOT on the first operand, and XOR, OR and AND on both operands. The bit group takes the first operand and the bit index, and then keeps only that bit, inverts it, sets it or clears it. A code outside the table passes the first operand through and leaves both flags as they were. Subtraction updates the zero flag, so a decrement followed by a conditional jump forms a counted loop.

Top module: `alu16`

## Requirements
- R1: Code 5'b00111 returns opA+opB and code 5'b00101 returns opA+opB+carryIn. In both cases carryOut is the carry out of bit 15.
- R2: Code 5'b01000 returns opA-opB and code 5'b00110 returns opA-opB-(1-carryIn). carryOut is 1 exactly when no borrow occurs. For plain subtraction this means opA >= opB.
- R3: Code 5'b01100 shifts opA left by one place and code 5'b01011 shifts it right by one place. The vacated bit is filled with 0, and carryOut receives the bit shifted out (bit 15 for left, bit 0 for right).
- R4: Code 5'b01010 rotates opA left by one place and code 5'b01001 rotates it right by one place. carryOut receives the bit that wraps around.
- R5: Code 5'b01101 returns ~opA. Codes 5'b01110, 5'b01111 and 5'b10000 return opA^opB, opA|opB and opA&opB respectively.
- R6: Codes 5'b10001, 5'b10010, 5'b10011 and 5'b10100 act on bit number bitIdx of opA. They respectively keep only that bit (all other bits become 0), invert it, set it to 1, or clear it to 0. All other bits pass unchanged, except under the keep-only code.
- R7: For every code in R1 to R6, zeroOut is 1 exactly when the 16-bit result is all zeros.
- R8: The logic codes of R5 and the bit codes of R6 give carryOut = 0.
- R9: Codes 0 to 4 and 21 to 31 return opA with carryOut = carryIn and zeroOut = zeroIn. They ignore opB and bitIdx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 16 | First operand; the only source for shifts, NOT and bit operations |
| opB | input | 16 | Second operand |
| opcode | input | 5 | Operation code |
| bitIdx | input | 4 | Bit number for the bit operations |
| carryIn | input | 1 | Saved carry flag |
| zeroIn | input | 1 | Saved zero flag |
| result | output | 16 | Operation result |
| carryOut | output | 1 | Next carry flag |
| zeroOut | output | 1 | Next zero flag |

## Verification
Random operands with random codes across the whole 5-bit space exercise every operation group and the unused codes. They are compared against a reference model in the bench. Directed cases then target the boundaries that random values rarely reach. Equal operands and opB one larger than opA show whether the no-borrow carry changes at the right point. 16'hFFFF plus one, with and without carry, separates a correct carry-out from a wrapped result that is merely zero. Bit indices 0 and 15 catch an off-by-one in the mask decoder. Patterns with only the end bits set show whether shifts fill with 0 and rotates wrap the bit that leaves.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  typedef enum logic [4:0] {
    OP_ADC = 5'd5,
    OP_SBC = 5'd6,
    OP_ADD = 5'd7,
    OP_SUB = 5'd8,
    OP_ROR = 5'd9,
    OP_ROL = 5'd10,
    OP_SHR = 5'd11,
    OP_SHL = 5'd12,
    OP_NOT = 5'd13,
    OP_XOR = 5'd14,
    OP_OR  = 5'd15,
    OP_AND = 5'd16,
    OP_MKB = 5'd17,
    OP_INB = 5'd18,
    OP_SEB = 5'd19,
    OP_CLB = 5'd20
  } aluOp_e;

  typedef enum logic [1:0] {
    UNIT_ARITH = 2'd0,
    UNIT_SHIFT = 2'd1,
    UNIT_LOGIC = 2'd2,
    UNIT_BIT   = 2'd3
  } aluUnit_e;

  typedef enum logic [1:0] {
    LG_NOT = 2'd0,
    LG_XOR = 2'd1,
    LG_OR  = 2'd2,
    LG_AND = 2'd3
  } logicSel_e;

  typedef enum logic [1:0] {
    BT_KEEP = 2'd0,
    BT_FLIP = 2'd1,
    BT_SET  = 2'd2,
    BT_CLR  = 2'd3
  } bitSel_e;

  typedef struct packed {
    logic      valid;
    aluUnit_e  unit;
    logic      subtract;
    logic      useCarry;
    logic      shLeft;
    logic      rotate;
    logic      clrCarry;
    logic      flagZero;
    logicSel_e logicSel;
    bitSel_e   bitSel;
  } aluCtrl_t;

endpackage

// File: rtl/alu16_ctrl.sv
module alu16_ctrl
  import alu16_pkg::*;
#(
  parameter int OPW = 5
) (
  input  logic [OPW-1:0] opcode,
  output aluCtrl_t       ctrl
);

  always_comb begin
    ctrl          = '0;
    ctrl.valid    = 1'b1;
    ctrl.flagZero = 1'b1;
    unique case (opcode)
      OP_ADD: begin ctrl.unit = UNIT_ARITH; end
      OP_ADC: begin ctrl.unit = UNIT_ARITH; ctrl.useCarry = 1'b1; end
      OP_SUB: begin ctrl.unit = UNIT_ARITH; ctrl.subtract = 1'b1; end
      OP_SBC: begin ctrl.unit = UNIT_ARITH; ctrl.subtract = 1'b1; ctrl.useCarry = 1'b1; end
      OP_SHL: begin ctrl.unit = UNIT_SHIFT; ctrl.shLeft = 1'b1; end
      OP_SHR: begin ctrl.unit = UNIT_SHIFT; end
      OP_ROL: begin ctrl.unit = UNIT_SHIFT; ctrl.shLeft = 1'b1; ctrl.rotate = 1'b1; end
      OP_ROR: begin ctrl.unit = UNIT_SHIFT; ctrl.rotate = 1'b1; end
      OP_NOT: begin ctrl.unit = UNIT_LOGIC; ctrl.clrCarry = 1'b1; ctrl.logicSel = LG_NOT; end
      OP_XOR: begin ctrl.unit = UNIT_LOGIC; ctrl.clrCarry = 1'b1; ctrl.logicSel = LG_XOR; end
      OP_OR:  begin ctrl.unit = UNIT_LOGIC; ctrl.clrCarry = 1'b1; ctrl.logicSel = LG_OR; end
      OP_AND: begin ctrl.unit = UNIT_LOGIC; ctrl.clrCarry = 1'b1; ctrl.logicSel = LG_AND; end
      OP_MKB: begin ctrl.unit = UNIT_BIT; ctrl.clrCarry = 1'b1; ctrl.bitSel = BT_KEEP; end
      OP_INB: begin ctrl.unit = UNIT_BIT; ctrl.clrCarry = 1'b1; ctrl.bitSel = BT_FLIP; end
      OP_SEB: begin ctrl.unit = UNIT_BIT; ctrl.clrCarry = 1'b1; ctrl.bitSel = BT_SET; end
      OP_CLB: begin ctrl.unit = UNIT_BIT; ctrl.clrCarry = 1'b1; ctrl.bitSel = BT_CLR; end
      default: begin
        ctrl.valid    = 1'b0;
        ctrl.flagZero = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/alu16_dpath.sv
module alu16_dpath
  import alu16_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int IDXW  = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [IDXW-1:0]  bitIdx,
  input  logic             carryIn,
  input  logic             zeroIn,
  input  aluCtrl_t         ctrl,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic             zeroOut
);

  localparam int MSB = WIDTH - 1;

  // adder: subtraction is opA + ~opB + carry-in, carry-out means no borrow
  logic [WIDTH-1:0] addendB;
  logic             addCin;
  logic [WIDTH:0]   sumWide;

  assign addendB = ctrl.subtract ? ~opB : opB;
  assign addCin  = ctrl.useCarry ? carryIn : ctrl.subtract;
  assign sumWide = {1'b0, opA} + {1'b0, addendB} + {{WIDTH{1'b0}}, addCin};

  // one-place shifter / rotator
  logic [WIDTH-1:0] shiftRes;
  logic             shiftOut;
  logic             fillBit;

  assign shiftOut = ctrl.shLeft ? opA[MSB] : opA[0];
  assign fillBit  = ctrl.rotate ? shiftOut : 1'b0;
  assign shiftRes = ctrl.shLeft ? {opA[MSB-1:0], fillBit} : {fillBit, opA[MSB:1]};

  // bitwise logic
  logic [WIDTH-1:0] logicRes;
  always_comb begin
    unique case (ctrl.logicSel)
      LG_NOT:  logicRes = ~opA;
      LG_XOR:  logicRes = opA ^ opB;
      LG_OR:   logicRes = opA | opB;
      default: logicRes = opA & opB;
    endcase
  end

  // single-bit mask decoder
  logic [WIDTH-1:0] bitMask;
  for (genvar i = 0; i < WIDTH; i++) begin : g_mask
    assign bitMask[i] = (bitIdx == IDXW'(i));
  end

  logic [WIDTH-1:0] bitRes;
  always_comb begin
    unique case (ctrl.bitSel)
      BT_KEEP: bitRes = opA & bitMask;
      BT_FLIP: bitRes = opA ^ bitMask;
      BT_SET:  bitRes = opA | bitMask;
      default: bitRes = opA & ~bitMask;
    endcase
  end

  // result and flag selection
  logic [WIDTH-1:0] unitRes;
  logic             unitCarry;
  always_comb begin
    unique case (ctrl.unit)
      UNIT_ARITH: begin unitRes = sumWide[WIDTH-1:0]; unitCarry = sumWide[WIDTH]; end
      UNIT_SHIFT: begin unitRes = shiftRes;           unitCarry = shiftOut;       end
      UNIT_LOGIC: begin unitRes = logicRes;           unitCarry = 1'b0;           end
      default:    begin unitRes = bitRes;             unitCarry = 1'b0;           end
    endcase
    if (ctrl.clrCarry) unitCarry = 1'b0;
  end

  always_comb begin
    if (ctrl.valid) begin
      result   = unitRes;
      carryOut = unitCarry;
    end else begin
      result   = opA;
      carryOut = carryIn;
    end
    zeroOut = ctrl.flagZero ? (result == '0) : zeroIn;
  end

endmodule

// File: rtl/alu16.sv
module alu16
  import alu16_pkg::*;
(
  input  logic [15:0] opA,
  input  logic [15:0] opB,
  input  logic [4:0]  opcode,
  input  logic [3:0]  bitIdx,
  input  logic        carryIn,
  input  logic        zeroIn,
  output logic [15:0] result,
  output logic        carryOut,
  output logic        zeroOut
);

  aluCtrl_t ctrl;

  alu16_ctrl #(.OPW(5)) u_ctrl (
    .opcode (opcode),
    .ctrl   (ctrl)
  );

  alu16_dpath #(.WIDTH(16), .IDXW(4)) u_dpath (
    .opA      (opA),
    .opB      (opB),
    .bitIdx   (bitIdx),
    .carryIn  (carryIn),
    .zeroIn   (zeroIn),
    .ctrl     (ctrl),
    .result   (result),
    .carryOut (carryOut),
    .zeroOut  (zeroOut)
  );

endmodule

// File: rtl/alu16_chk.sv
module alu16_chk
  import alu16_pkg::*;
(
  input logic [15:0] opA,
  input logic [15:0] opB,
  input logic [4:0]  opcode,
  input logic [3:0]  bitIdx,
  input logic        carryIn,
  input logic        zeroIn,
  input logic [15:0] result,
  input logic        carryOut,
  input logic        zeroOut
);

  logic defined;
  logic isBitOp;
  logic isLogicOp;
  logic [15:0] sel;

  assign defined   = (opcode >= 5'd5) && (opcode <= 5'd20);
  assign isBitOp   = (opcode >= 5'd17) && (opcode <= 5'd20);
  assign isLogicOp = (opcode >= 5'd13) && (opcode <= 5'd16);
  assign sel       = 16'd1 << bitIdx;

  always_comb begin
    if (opcode == OP_ADD)
      assert_add_carry_R1: assert ({carryOut, result} == ({1'b0, opA} + {1'b0, opB}));
    if (opcode == OP_SUB)
      assert_sub_noborrow_R2: assert (carryOut == (opA >= opB));
    if (isBitOp)
      assert_bit_local_R6: assert (((result ^ opA) & ~sel) == 16'd0 || opcode == OP_MKB);
    if (defined)
      assert_zero_flag_R7: assert (zeroOut == (result == 16'd0));
    if (isBitOp || isLogicOp)
      assert_carry_clear_R8: assert (carryOut == 1'b0);
    if (!defined)
      assert_unused_hold_R9: assert (result == opA && carryOut == carryIn && zeroOut == zeroIn);
  end

endmodule

bind alu16 alu16_chk u_chk (
  .opA      (opA),
  .opB      (opB),
  .opcode   (opcode),
  .bitIdx   (bitIdx),
  .carryIn  (carryIn),
  .zeroIn   (zeroIn),
  .result   (result),
  .carryOut (carryOut),
  .zeroOut  (zeroOut)
);

// File: tb/alu16_tb.sv
module alu16_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM   = 3000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] opA = '0, opB = '0;
  logic [4:0]  opcode = '0;
  logic [3:0]  bitIdx = '0;
  logic        carryIn = 1'b0, zeroIn = 1'b0;
  logic [15:0] result;
  logic        carryOut, zeroOut;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu16 u_dut (
    .opA(opA), .opB(opB), .opcode(opcode), .bitIdx(bitIdx),
    .carryIn(carryIn), .zeroIn(zeroIn),
    .result(result), .carryOut(carryOut), .zeroOut(zeroOut)
  );

  // reference model: returns {carry, zero, result}
  function automatic logic [17:0] refModel(input logic [4:0] op, input logic [15:0] a,
                                           input logic [15:0] b, input logic [3:0] k,
                                           input logic ci, input logic zi);
    logic [16:0] w;
    logic [15:0] r;
    logic        c;
    logic [15:0] m;
    m = 16'd1 << k;
    r = a; c = 1'b0;
    case (op)
      5'd7:  begin w = a + b;                 r = w[15:0]; c = w[16]; end
      5'd5:  begin w = a + b + ci;            r = w[15:0]; c = w[16]; end
      5'd8:  begin r = a - b;                 c = (a >= b); end
      5'd6:  begin r = a - b - {15'd0, ~ci};  c = ({1'b0, a} >= ({1'b0, b} + {16'd0, ~ci})); end
      5'd12: begin r = a << 1;                c = a[15]; end
      5'd11: begin r = a >> 1;                c = a[0]; end
      5'd10: begin r = {a[14:0], a[15]};      c = a[15]; end
      5'd9:  begin r = {a[0], a[15:1]};       c = a[0]; end
      5'd13: r = ~a;
      5'd14: r = a ^ b;
      5'd15: r = a | b;
      5'd16: r = a & b;
      5'd17: r = a & m;
      5'd18: r = a ^ m;
      5'd19: r = a | m;
      5'd20: r = a & ~m;
      default: return {ci, zi, a};
    endcase
    return {c, (r == 16'd0), r};
  endfunction

  function automatic string reqOf(input logic [4:0] op);
    if (op == 5'd7 || op == 5'd5) return "R1";
    if (op == 5'd8 || op == 5'd6) return "R2";
    if (op == 5'd12 || op == 5'd11) return "R3";
    if (op == 5'd10 || op == 5'd9) return "R4";
    if (op >= 5'd13 && op <= 5'd16) return "R5";
    if (op >= 5'd17 && op <= 5'd20) return "R6";
    return "R9";
  endfunction

  task automatic apply(input logic [4:0] op, input logic [15:0] a, input logic [15:0] b,
                       input logic [3:0] k, input logic ci, input logic zi);
    logic [17:0] exp;
    string rq;
    @(posedge clk);
    opcode = op; opA = a; opB = b; bitIdx = k; carryIn = ci; zeroIn = zi;
    @(negedge clk);
    exp = refModel(op, a, b, k, ci, zi);
    rq  = reqOf(op);
    checks++;
    if (result !== exp[15:0]) begin
      fails++;
      $display("FAIL %s result op=%0d a=%h b=%h k=%0d: got %h exp %h", rq, op, a, b, k, result, exp[15:0]);
    end
    checks++;
    if (carryOut !== exp[17]) begin
      fails++;
      $display("FAIL %s%s carry op=%0d a=%h b=%h ci=%b: got %b exp %b", rq,
               ((op >= 5'd13 && op <= 5'd20) ? "/R8" : ""), op, a, b, ci, carryOut, exp[17]);
    end
    checks++;
    if (zeroOut !== exp[16]) begin
      fails++;
      $display("FAIL %s zero op=%0d a=%h b=%h: got %b exp %b", (rq == "R9") ? "R9" : "R7",
               op, a, b, zeroOut, exp[16]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // idle state: unused code 0 with zero operands passes through
    apply(5'd0, 16'h0000, 16'h0000, 4'd0, 1'b0, 1'b0);          // R9
    // R1 corners
    apply(5'd7, 16'hFFFF, 16'h0001, 4'd0, 1'b0, 1'b0);
    apply(5'd5, 16'hFFFF, 16'h0000, 4'd0, 1'b1, 1'b0);
    apply(5'd5, 16'h1234, 16'h0001, 4'd0, 1'b0, 1'b1);
    // R2 corners
    apply(5'd8, 16'h0005, 16'h0005, 4'd0, 1'b0, 1'b0);
    apply(5'd8, 16'h0005, 16'h0006, 4'd0, 1'b1, 1'b0);
    apply(5'd6, 16'h0005, 16'h0005, 4'd0, 1'b0, 1'b0);
    apply(5'd6, 16'h0005, 16'h0004, 4'd0, 1'b0, 1'b0);
    apply(5'd6, 16'h0000, 16'h0000, 4'd0, 1'b1, 1'b0);
    // R3 / R4 end-bit patterns
    apply(5'd12, 16'h8001, 16'h0000, 4'd0, 1'b0, 1'b0);
    apply(5'd11, 16'h8001, 16'h0000, 4'd0, 1'b1, 1'b0);
    apply(5'd12, 16'h8000, 16'h0000, 4'd0, 1'b0, 1'b0);
    apply(5'd10, 16'h8000, 16'h0000, 4'd0, 1'b0, 1'b0);
    apply(5'd9,  16'h0001, 16'h0000, 4'd0, 1'b0, 1'b0);
    // R5
    apply(5'd13, 16'hFFFF, 16'h1234, 4'd0, 1'b1, 1'b0);
    apply(5'd14, 16'hA5A5, 16'hA5A5, 4'd0, 1'b1, 1'b0);
    apply(5'd15, 16'h0F00, 16'h00F0, 4'd0, 1'b1, 1'b1);
    apply(5'd16, 16'hF0F0, 16'h0F0F, 4'd0, 1'b1, 1'b0);
    // R6 at both ends of the index range
    apply(5'd17, 16'hFFFF, 16'h0000, 4'd0,  1'b1, 1'b0);
    apply(5'd17, 16'h7FFF, 16'h0000, 4'd15, 1'b1, 1'b0);
    apply(5'd18, 16'h0000, 16'h0000, 4'd15, 1'b1, 1'b1);
    apply(5'd19, 16'h0000, 16'h0000, 4'd0,  1'b1, 1'b1);
    apply(5'd20, 16'h8000, 16'h0000, 4'd15, 1'b1, 1'b0);
    // R9: unused codes ignore opB and bitIdx, hold flags
    apply(5'd4,  16'h0000, 16'hFFFF, 4'd7, 1'b1, 1'b0);
    apply(5'd21, 16'hBEEF, 16'h1111, 4'd3, 1'b0, 1'b1);
    apply(5'd31, 16'h0000, 16'hFFFF, 4'd9, 1'b1, 1'b0);
    // random mix over the whole code space
    for (int n = 0; n < N_RANDOM; n++) begin
      logic [15:0] ra, rb;
      ra = 16'($urandom);
      rb = 16'($urandom);
      if (($urandom % 8) == 0) rb = ra;
      apply(5'($urandom), ra, rb, 4'($urandom), 1'($urandom), 1'($urandom));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule